// File: doc/BRIEF.md
# Indirect Radio Register Window

This block lets a host reach a bank of 128 radio registers, each 16 bits wide, through three 16-bit ports on a small memory-mapped bus. The host first stores a register index in the offset port. It then reads or writes the chosen register through the low data port. The high data port carries the upper half of a 32-bit radio identifier, which sits at the reserved offset 1. The identifier comes in as a constant input.

Reads go through an offset translation stage before the bank lookup. The stage is chosen by a PHY-type input and, for the B type, by a field of the identifier. After translation, bits 6:0 pick the entry. Writes always use the untranslated offset, reduced to bits 6:0.

Bus accesses last one cycle. A read returns its data on `rdata_o` one cycle after the request, and `rvalid_o` is high in that same cycle.

Top module: `radio_reg_window`

## Requirements
- R1: A write to address 0x3F6 stores the full 16-bit offset. The offset is 0 after reset. A read of 0x3F6 returns the stored offset.
- R2: A write to 0x3FA stores the write data in entry offset[6:0]. This holds when the stored offset is not 1, and it includes offsets above 0x7F, for example 0x81 writes entry 1.
- R3: A read request sets `rvalid_o` high in the next cycle only. In that cycle `rdata_o` carries the read value. A write request never raises `rvalid_o`.
- R4: With phy_type_i = 0 (A type), a read of 0x3FA at an offset other than 1 returns entry (offset | 0x40)[6:0].
- R5: With phy_type_i = 2 (G type), a read of 0x3FA at an offset other than 1 returns entry (offset | 0x80)[6:0].
- R6: With phy_type_i = 1 (B type), the read offset depends on m = radio_id_i & 0x0FFFF000:
  - If m = 0x02053000, the offset is offset+0x80 when offset < 0x70, and is unchanged otherwise.
  - If m = 0x02055000, the offset is offset+0x70 when offset < 0x80, and is unchanged otherwise.
  - If m = 0x02050000, the offset is offset | 0x80.
  - For any other m, and for phy_type_i = 3, the offset is not translated.
  - In every case, bits 6:0 of the result select the entry.
- R7: When the stored offset is exactly 1, whatever the PHY type, a read of 0x3FA returns radio_id_i[15:0] and a read of 0x3F8 returns radio_id_i[31:16].
- R8: Writes to 0x3FA while the stored offset is 1 change no entry. Writes to 0x3F8 change no entry.
- R9: A read of 0x3F8 at any stored offset other than 1 returns 0. A read of any address other than the three ports returns 0.
- R10: After reset, every entry is 0, `rdata_o` is 0 and `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Bus address |
| wdata_i | input | 16 | Write data |
| phy_type_i | input | 2 | PHY type: 0 A, 1 B, 2 G, 3 none |
| radio_id_i | input | 32 | Constant radio identifier |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bank is first filled with a distinct value per entry, so every read shows which entry was selected.

The translation rules are then tried with offsets on both sides of each comparison threshold:
- 0x6F and 0x75 around the below-0x70 rule.
- 0x7F and 0x90 around the below-0x80 rule.
- Wide offsets whose upper bits must be dropped.

Identifiers are chosen to tell the masked field apart from the unmasked bits: the same field with different low or top nibbles, and an unknown field that must not translate.

Offset 1 is checked against its alias 0x81 on both reads and blocked writes. This separates the identifier path from bank entry 1.

// File: rtl/radio_win_pkg.sv
package radio_win_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ID_W   = 32;
  localparam int unsigned DEPTH  = 128;
  localparam int unsigned IDX_W  = $clog2(DEPTH);

  typedef enum logic [1:0] {
    PHY_A    = 2'd0,
    PHY_B    = 2'd1,
    PHY_G    = 2'd2,
    PHY_NONE = 2'd3
  } phy_t;

  localparam logic [ID_W-1:0]   B_ID_MASK = 32'h0FFF_F000;
  localparam logic [ID_W-1:0]   B_ID_ADD8 = 32'h0205_3000;
  localparam logic [ID_W-1:0]   B_ID_ADD7 = 32'h0205_5000;
  localparam logic [ID_W-1:0]   B_ID_OR8  = 32'h0205_0000;
  localparam logic [DATA_W-1:0] ID_OFFSET = 16'h0001;
endpackage

// File: rtl/rw_offset_reg.sv
module rw_offset_reg
  import radio_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] off_o
);
  logic [DATA_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else if (wr_i) off_q <= wdata_i;
  end

  assign off_o = off_q;

  AST_OFFSET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> off_o == $past(wdata_i)); // R1
  AST_OFFSET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(off_o)); // R1
endmodule

// File: rtl/rw_read_xlate.sv
module rw_read_xlate
  import radio_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phy_t              phy_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ID_W-1:0]   id_field;
  logic [DATA_W-1:0] xoff;
  logic [DATA_W-IDX_W-1:0] unused_xoff_hi;

  assign id_field = id_i & B_ID_MASK;

  always_comb begin
    xoff = off_i;
    if (off_i != ID_OFFSET) begin
      unique case (phy_i)
        PHY_A: xoff = off_i | 16'h0040;
        PHY_G: xoff = off_i | 16'h0080;
        PHY_B: begin
          if (id_field == B_ID_ADD8) begin
            if (off_i < 16'h0070) xoff = off_i + 16'h0080;
          end else if (id_field == B_ID_ADD7) begin
            if (off_i < 16'h0080) xoff = off_i + 16'h0070;
          end else if (id_field == B_ID_OR8) begin
            xoff = off_i | 16'h0080;
          end
        end
        default: xoff = off_i;
      endcase
    end
  end

  assign idx_o          = xoff[IDX_W-1:0];
  assign unused_xoff_hi = xoff[DATA_W-1:IDX_W];

  AST_A_SETS_BIT6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_i == PHY_A && off_i != ID_OFFSET) |-> idx_o[6]); // R4
  AST_G_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_i == PHY_G) |-> idx_o == off_i[IDX_W-1:0]); // R5
  AST_NONE_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_i == PHY_NONE) |-> idx_o == off_i[IDX_W-1:0]); // R6
endmodule

// File: rtl/rw_reg_bank.sv
module rw_reg_bank
  import radio_win_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

  AST_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(widx_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/radio_reg_window.sv
module radio_reg_window
  import radio_win_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] ADDR_OFF = 12'h3F6,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 12'h3F8,
  parameter logic [ADDR_W-1:0] ADDR_LO  = 12'h3FA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [1:0]        phy_type_i,
  input  logic [31:0]       radio_id_i,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o
);
  logic              sel_off, sel_hi, sel_lo, rd_req;
  logic              off_wr, bank_we, is_id;
  logic [DATA_W-1:0] off_q, bank_rd, rd_val, rdata_q;
  logic [IDX_W-1:0]  rd_idx;
  logic              rvalid_q;

  assign sel_off = req_i && addr_i == ADDR_OFF;
  assign sel_hi  = req_i && addr_i == ADDR_HI;
  assign sel_lo  = req_i && addr_i == ADDR_LO;
  assign rd_req  = req_i && !we_i;
  assign off_wr  = sel_off && we_i;
  assign is_id   = off_q == ID_OFFSET;
  assign bank_we = sel_lo && we_i && !is_id;

  rw_offset_reg u_off (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (off_wr),
    .wdata_i(wdata_i),
    .off_o  (off_q)
  );

  rw_read_xlate u_xlate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .phy_i (phy_t'(phy_type_i)),
    .id_i  (radio_id_i),
    .off_i (off_q),
    .idx_o (rd_idx)
  );

  rw_reg_bank u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .widx_i (off_q[IDX_W-1:0]),
    .wdata_i(wdata_i),
    .ridx_i (rd_idx),
    .rdata_o(bank_rd)
  );

  always_comb begin
    rd_val = '0;
    if (sel_off)     rd_val = off_q;
    else if (sel_hi) rd_val = is_id ? radio_id_i[31:16] : '0;
    else if (sel_lo) rd_val = is_id ? radio_id_i[15:0] : bank_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o); // R3
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o); // R3
  AST_ID_HIGH_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel_hi && is_id) |=> rdata_o == $past(radio_id_i[31:16])); // R7
  AST_ID_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel_lo && is_id) |=> rdata_o == $past(radio_id_i[15:0])); // R7
  AST_ID_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_lo && we_i && is_id) |-> !bank_we); // R8
  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel_hi && !is_id) |=> rdata_o == '0); // R9
endmodule

// File: tb/radio_reg_window_tb_top.sv
module radio_reg_window_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  phy_type_i = 2'd2;
  logic [31:0] radio_id_i = 32'h0;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [11:0] A_OFF = 12'h3F6;
  localparam logic [11:0] A_HI  = 12'h3F8;
  localparam logic [11:0] A_LO  = 12'h3FA;

  always #4 clk_i = ~clk_i;

  radio_reg_window dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .phy_type_i(phy_type_i),
    .radio_id_i(radio_id_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [15:0] pat(input logic [6:0] k);
    return 16'hC000 + 16'(k) * 16'd3;
  endfunction

  // {phy, id, offset, expected entry}
  localparam int NV = 14;
  localparam logic [56:0] VEC [NV] = '{
    {2'd0, 32'h0000_0000, 16'h0005, 7'h45},
    {2'd0, 32'h0000_0000, 16'h007F, 7'h7F},
    {2'd0, 32'h0000_0000, 16'h1234, 7'h74},
    {2'd2, 32'h0000_0000, 16'h0023, 7'h23},
    {2'd2, 32'h0000_0000, 16'h00C5, 7'h45},
    {2'd1, 32'h0205_3ABC, 16'h006F, 7'h6F},
    {2'd1, 32'h0205_3000, 16'h0075, 7'h75},
    {2'd1, 32'h0205_5FFF, 16'h0010, 7'h00},
    {2'd1, 32'h0205_5000, 16'h007F, 7'h6F},
    {2'd1, 32'h0205_5000, 16'h0090, 7'h10},
    {2'd1, 32'h0205_0123, 16'h0033, 7'h33},
    {2'd1, 32'h1205_0000, 16'h0044, 7'h44},
    {2'd1, 32'h0205_1000, 16'h0144, 7'h44},
    {2'd3, 32'h0205_5000, 16'h0099, 7'h19}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d, output logic v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o; v = rvalid_o;
    req_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    logic v;
    repeat (3) @(negedge clk_i);
    check("R10 rdata reset", 32'(rdata_o), 32'h0);
    check("R10 rvalid reset", 32'(rvalid_o), 32'h0);
    rst_ni = 1'b1;
    bus_rd(A_OFF, d, v);
    check("R1 offset after reset", 32'(d), 32'h0);
    check("R3 rvalid after read", 32'(v), 32'h1);
    phy_type_i = 2'd2;
    bus_rd(A_LO, d, v);
    check("R10 entry 0 reset", 32'(d), 32'h0);
    bus_wr(A_OFF, 16'h0045);
    bus_rd(A_LO, d, v);
    check("R10 entry 0x45 reset", 32'(d), 32'h0);

    // fill bank; entry 1 through its alias 0x81
    for (int k = 0; k < 128; k++) begin
      bus_wr(A_OFF, (k == 1) ? 16'h0081 : 16'(k));
      bus_wr(A_LO, pat(7'(k)));
    end
    check("R3 no rvalid after write", 32'(rvalid_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      phy_type_i = VEC[i][56:55];
      radio_id_i = VEC[i][54:23];
      bus_wr(A_OFF, VEC[i][22:7]);
      bus_rd(A_LO, d, v);
      case (VEC[i][56:55])
        2'd0:    check($sformatf("R4 vec %0d", i), 32'(d), 32'(pat(VEC[i][6:0])));
        2'd2:    check($sformatf("R5 vec %0d", i), 32'(d), 32'(pat(VEC[i][6:0])));
        default: check($sformatf("R6 vec %0d", i), 32'(d), 32'(pat(VEC[i][6:0])));
      endcase
      check($sformatf("R3 rvalid vec %0d", i), 32'(v), 32'h1);
    end

    bus_rd(A_OFF, d, v);
    check("R1 offset readback", 32'(d), 32'h0099);

    // identifier at offset 1
    radio_id_i = 32'h0205_3ABC;
    for (int p = 0; p < 4; p++) begin
      phy_type_i = 2'(p);
      bus_wr(A_OFF, 16'h0001);
      bus_rd(A_HI, d, v);
      check($sformatf("R7 id high phy %0d", p), 32'(d), 32'h0205);
      bus_wr(A_OFF, 16'h0001);
      bus_rd(A_LO, d, v);
      check($sformatf("R7 id low phy %0d", p), 32'(d), 32'h3ABC);
    end

    bus_wr(A_OFF, 16'h0001);
    bus_wr(A_LO, 16'hDEAD);
    phy_type_i = 2'd2;
    bus_wr(A_OFF, 16'h0081);
    bus_rd(A_LO, d, v);
    check("R8 entry 1 after id write", 32'(d), 32'(pat(7'h01)));
    bus_rd(A_HI, d, v);
    check("R9 high port at 0x81", 32'(d), 32'h0);

    bus_wr(A_OFF, 16'h0005);
    bus_wr(A_HI, 16'hBEEF);
    bus_rd(A_LO, d, v);
    check("R8 high port write ignored", 32'(d), 32'(pat(7'h05)));
    bus_rd(A_HI, d, v);
    check("R9 high port at 5", 32'(d), 32'h0);
    bus_rd(12'h100, d, v);
    check("R9 unmapped read", 32'(d), 32'h0);
    check("R3 rvalid unmapped", 32'(v), 32'h1);

    bus_wr(A_OFF, 16'h0285);
    bus_wr(A_LO, 16'h7E57);
    bus_wr(A_OFF, 16'h0005);
    bus_rd(A_LO, d, v);
    check("R2 wide offset write", 32'(d), 32'h7E57);

    done = 1'b1;
    finish_run();
  end
endmodule